// File: doc/BRIEF.md
# UART Receive Queue with Idle Timeout

This block sits between a serial deserializer and the host side of a 16550-style UART. Each received byte and each line-break event goes into a 16-deep first-in first-out store. The host pops bytes with a read strobe and sees the oldest byte on `rd_data` without waiting a cycle. A control byte written by the host turns queue mode on or off, selects how full the queue must be before `trig_hit` is raised, and can request a flush of the receive store or of the neighbouring transmit store.

When queue mode is off, the block falls back to a single holding register. In queue mode an idle counter watches for data that has been left waiting. If four character times (given in clock ticks on `char_ticks`) pass with no arrival and no read while bytes remain, `tmo_pend` is raised. An arrival into a full queue never disturbs the stored bytes. It only sets the overrun flag, which the host clears with a status-clear strobe. A break arrives as a zero byte and raises the break flag.

Top module: `uart_rxq`

## Requirements
- R1: `ctl_q` holds the last control write ANDed with 0xC9 (bits 7, 6, 3 and 0 are kept). `tx_flush` is high during a control write whose bit 2 is set or whose bit 0 differs from the current `ctl_q[0]`.
- R2: A control write with bit 1 set, or with bit 0 different from `ctl_q[0]`, empties the receive queue. It also clears `tmo_pend` and `brk_flag`. Bit 0 set means queue mode.
- R3: Control bits 7:6 select the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode `trig_hit` = `data_ready` and `rx_level` >= threshold. In holding mode `trig_hit` equals `data_ready`.
- R4: In queue mode bytes leave in arrival order. `rd_data` shows the oldest byte combinationally, a read strobe removes it at the clock edge, and `rx_level` counts the stored bytes.
- R5: A byte arriving while the queue holds 16 bytes and no read is made is discarded, the stored bytes stay unchanged, and `ovr_flag` is set. `stat_clr` clears `ovr_flag` and `brk_flag`; a new event in the same cycle wins.
- R6: A read and an arrival in the same cycle on a full queue accept the new byte with no overrun, and the level stays 16.
- R7: A break event stores the byte 0x00 and sets `brk_flag` and `data_ready`. If `rx_valid` is high in the same cycle, the break takes its place.
- R8: `brk_flag` stays set while stored data remains. A read that empties the queue (or any read in holding mode) clears `data_ready` and `brk_flag`.
- R9: In queue mode `tmo_pend` rises exactly 4 × `char_ticks` clock edges after the last arrival or the last read that left data behind, while data remains.
- R10: Any read clears `tmo_pend`. An empty queue never raises it.
- R11: A read of an empty queue returns 0x00 and leaves `rx_level` at zero.
- R12: In holding mode an arriving byte replaces the holding register and sets `data_ready`. If `data_ready` was already set and no read is made in that cycle, `ovr_flag` is set too.
- R13: `rx_level` never exceeds the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer presents a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event this cycle |
| rd_strobe | input | 1 | Host pops one byte at this edge |
| rd_data | output | 8 | Oldest byte (queue mode) or holding register |
| stat_clr | input | 1 | Host status read: clears overrun and break |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| char_ticks | input | 16 | One character time in clock ticks |
| data_ready | output | 1 | Received data available |
| brk_flag | output | 1 | Break received |
| ovr_flag | output | 1 | Byte lost to overrun |
| trig_hit | output | 1 | Trigger threshold reached |
| tmo_pend | output | 1 | Idle timeout pending |
| rx_level | output | 5 | Bytes stored in the queue |
| ctl_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | Flush request for the transmit store |

## Verification
The main collision is a host pop landing in the same cycle as a deserializer arrival while the queue is full. The bench fills the queue to 16, clears the overrun flag, then raises `rd_strobe` and `rx_valid` together. It then expects the overrun flag still clear, the level still 16, and the drained sequence to end with the new byte after the fifteen remaining older ones. A second collision is a break coinciding with a plain byte. There the bench expects one stored entry, and that entry reads back as 0x00.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_QUARTER  = 2'b01,
    TRIG_HALF     = 2'b10,
    TRIG_NEARFULL = 2'b11
  } trig_code_e;

  // Threshold in bytes for a trigger code; scales with the queue depth.
  function automatic logic [15:0] trig_level(input trig_code_e code, input int unsigned depth);
    case (code)
      TRIG_ONE:     return 16'd1;
      TRIG_QUARTER: return 16'(depth / 4);
      TRIG_HALF:    return 16'(depth / 2);
      default:      return 16'(depth - 2);
    endcase
  endfunction

  // Idle window: four character times.
  function automatic logic [33:0] idle_limit(input logic [31:0] ticks);
    return {ticks, 2'b00};
  endfunction

endpackage

// File: rtl/rxq_ctl_decode.sv
module rxq_ctl_decode
  import uart_rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q,
  output logic       fifo_en,
  output trig_code_e trig,
  output logic       rx_flush,
  output logic       tx_flush
);
  localparam logic [7:0] KEEP_MASK = 8'hC9;

  logic en_flip;

  assign en_flip  = wr && (wdata[0] != ctl_q[0]);
  assign rx_flush = (wr && wdata[1]) || en_flip;
  assign tx_flush = (wr && wdata[2]) || en_flip;
  assign fifo_en  = ctl_q[0];
  assign trig     = trig_code_e'(ctl_q[7:6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata & KEEP_MASK;
  end

  // R1: a mode flip always requests both flushes
  assert_flip_flushes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wdata[0] != fifo_en)) |-> (rx_flush && tx_flush));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          pushed,
  output logic          popped,
  output logic          dropped
);
  logic [DW-1:0] slot [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign popped  = pop && !empty;
  assign pushed  = push && (!full || popped);
  assign dropped = push && !pushed;
  assign dout    = empty ? '0 : slot[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot[i] <= '0;
      else if (flush)                              slot[i] <= '0;
      else if (pushed && (wr_ptr == AW'(i)))       slot[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (pushed) wr_ptr <= wr_ptr + AW'(1);
      if (popped) rd_ptr <= rd_ptr + AW'(1);
      case ({pushed, popped})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R5: a discarded arrival leaves the queue full
  assert_drop_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && full) |=> (level == CW'(DEPTH)));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import uart_rxq_pkg::*;
#(
  parameter int CT_W = 16,
  localparam int LW  = CT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            active,
  input  logic            restart,
  input  logic            ack,
  input  logic [CT_W-1:0] char_ticks,
  output logic            pend
);
  logic [LW-1:0] cnt;
  logic [LW-1:0] limit;
  logic          hit;

  assign limit = LW'(idle_limit(32'(char_ticks)));
  assign hit   = (cnt + LW'(1)) >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (restart || !active) begin
        cnt <= '0;
      end else if (!pend) begin
        if (hit) pend <= 1'b1;
        else     cnt  <= cnt + LW'(1);
      end
    end
  end

  assert_pend_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(active));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CT_W  = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_byte,
  input  logic            rx_break,
  input  logic            rd_strobe,
  output logic [DW-1:0]   rd_data,
  input  logic            stat_clr,
  input  logic            ctl_wr,
  input  logic [7:0]      ctl_wdata,
  input  logic [CT_W-1:0] char_ticks,
  output logic            data_ready,
  output logic            brk_flag,
  output logic            ovr_flag,
  output logic            trig_hit,
  output logic            tmo_pend,
  output logic [CW-1:0]   rx_level,
  output logic [7:0]      ctl_q,
  output logic            tx_flush
);
  logic          fifo_en, rx_flush;
  trig_code_e    trig;
  logic          arrive;
  logic [DW-1:0] arr_byte;
  logic [DW-1:0] q_dout, hold_q;
  logic          hold_full;
  logic          q_empty, q_pushed, q_popped, q_dropped;
  logic          q_drains, hold_ovr, brk_clear_rd;

  rxq_ctl_decode u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .ctl_q    (ctl_q),
    .fifo_en  (fifo_en),
    .trig     (trig),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  // A break stands in for any byte offered in the same cycle.
  assign arrive   = rx_valid || rx_break;
  assign arr_byte = rx_break ? '0 : rx_byte;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (rx_flush),
    .push    (fifo_en && arrive),
    .pop     (fifo_en && rd_strobe),
    .din     (arr_byte),
    .dout    (q_dout),
    .level   (rx_level),
    .empty   (q_empty),
    .pushed  (q_pushed),
    .popped  (q_popped),
    .dropped (q_dropped)
  );

  rxq_idle_timer #(.CT_W(CT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (rx_flush || !fifo_en),
    .active     (fifo_en && !q_empty),
    .restart    (arrive || q_popped),
    .ack        (rd_strobe),
    .char_ticks (char_ticks),
    .pend       (tmo_pend)
  );

  // Holding-register path used when queue mode is off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (rx_flush) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (!fifo_en) begin
      if (arrive) begin
        hold_q    <= arr_byte;
        hold_full <= 1'b1;
      end else if (rd_strobe) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign q_drains     = q_popped && !q_pushed && (rx_level == CW'(1));
  assign hold_ovr     = !fifo_en && arrive && hold_full && !rd_strobe;
  assign brk_clear_rd = fifo_en ? q_drains : rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      brk_flag <= 1'b0;
    else if (rx_flush)               brk_flag <= 1'b0;
    else if (rx_break)               brk_flag <= 1'b1;
    else if (stat_clr || brk_clear_rd) brk_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovr_flag <= 1'b0;
    else if (q_dropped || hold_ovr)  ovr_flag <= 1'b1;
    else if (stat_clr)               ovr_flag <= 1'b0;
  end

  assign data_ready = fifo_en ? !q_empty : hold_full;
  assign rd_data    = fifo_en ? q_dout : hold_q;
  assign trig_hit   = data_ready &&
                      (!fifo_en || (32'(rx_level) >= 32'(trig_level(trig, DEPTH))));

  assert_break_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !ctl_wr) |=> (data_ready && brk_flag));

  assert_flip_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fifo_en) |-> (rx_level == '0));

  assert_read_acks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !ctl_wr) |=> !tmo_pend);

  assert_hold_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_valid && data_ready && !rd_strobe && !ctl_wr) |=> ovr_flag);

endmodule

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rd_strobe = 1'b0, stat_clr = 1'b0, ctl_wr = 1'b0;
  logic [7:0]  rx_byte = '0, ctl_wdata = '0, rd_data, ctl_q;
  logic [15:0] char_ticks = 16'd3;
  logic        data_ready, brk_flag, ovr_flag, trig_hit, tmo_pend, tx_flush;
  logic [4:0]  rx_level;
  int          errs = 0, checks = 0;
  bit          done = 0;
  logic [7:0]  d;
  logic        txf;

  uart_rxq #(.DEPTH(16), .DW(8), .CT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .stat_clr(stat_clr), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .char_ticks(char_ticks), .data_ready(data_ready),
    .brk_flag(brk_flag), .ovr_flag(ovr_flag), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .rx_level(rx_level), .ctl_q(ctl_q), .tx_flush(tx_flush)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; cyc(); rx_valid = 1'b0;
  endtask

  task automatic brk_ev();
    rx_break = 1'b1; cyc(); rx_break = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_strobe = 1'b1; #1; v = rd_data; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v, output logic f);
    ctl_wr = 1'b1; ctl_wdata = v; #1; f = tx_flush; @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic clr();
    stat_clr = 1'b1; cyc(); stat_clr = 1'b0;
  endtask

  function automatic int lvl_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  initial begin
    #(CLK_NS * 100000);
    checks++; errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R12 reset ready", data_ready, 0);
    chk("R1 reset ctl", ctl_q, 0);
    chk("R13 reset level", rx_level, 0);
    chk("R10 reset pend", tmo_pend, 0);
    chk("R5 reset ovr", ovr_flag, 0);
    chk("R8 reset brk", brk_flag, 0);

    // holding mode
    push(8'hA5);
    chk("R12 ready", data_ready, 1);
    chk("R12 data", rd_data, 8'hA5);
    chk("R3 hold trig", trig_hit, 1);
    push(8'h3C);
    chk("R12 overrun", ovr_flag, 1);
    chk("R12 replace", rd_data, 8'h3C);
    chk("R12 level", rx_level, 0);
    clr();
    chk("R5 clear ovr", ovr_flag, 0);
    rd(d);
    chk("R12 read data", d, 8'h3C);
    chk("R12 read clears", data_ready, 0);
    brk_ev();
    chk("R7 hold brk", brk_flag, 1);
    chk("R7 hold zero", rd_data, 0);
    rd(d);
    chk("R8 hold read brk", brk_flag, 0);

    // enter queue mode
    ctl(8'h01, txf);
    chk("R1 flip txf", txf, 1);
    chk("R1 ctl", ctl_q, 8'h01);

    // trigger sweep
    for (int code = 0; code < 4; code++) begin
      ctl(8'((code << 6) | 3), txf);
      chk("R2 flush level", rx_level, 0);
      for (int n = 1; n <= 16; n++) begin
        push(8'(n * 7 + code));
        chk("R3 trig", trig_hit, (n >= lvl_of(code)) ? 1 : 0);
        chk("R4 level", rx_level, n);
      end
    end

    // overrun on full
    push(8'hEE);
    chk("R5 overrun", ovr_flag, 1);
    chk("R5 level", rx_level, 16);
    clr();
    chk("R5 cleared", ovr_flag, 0);

    // simultaneous read and arrival on full
    rd_strobe = 1'b1; rx_valid = 1'b1; rx_byte = 8'h99; #1; d = rd_data;
    @(negedge clk); rd_strobe = 1'b0; rx_valid = 1'b0;
    chk("R6 head", d, 8'd10);
    chk("R6 no ovr", ovr_flag, 0);
    chk("R6 level", rx_level, 16);
    for (int n = 2; n <= 16; n++) begin
      rd(d);
      chk("R4 order", d, 8'(n * 7 + 3));
    end
    rd(d);
    chk("R6 tail", d, 8'h99);
    chk("R8 drained", data_ready, 0);
    chk("R3 drained trig", trig_hit, 0);
    rd(d);
    chk("R11 empty data", d, 0);
    chk("R11 empty level", rx_level, 0);

    // break in queue mode
    push(8'h11); push(8'h22); brk_ev();
    chk("R7 brk", brk_flag, 1);
    chk("R7 level", rx_level, 3);
    rd(d); chk("R4 brk seq", d, 8'h11); chk("R8 brk held", brk_flag, 1);
    rd(d); chk("R4 brk seq", d, 8'h22); chk("R8 brk held", brk_flag, 1);
    rd(d); chk("R7 zero", d, 0);
    chk("R8 brk cleared", brk_flag, 0);
    chk("R8 ready cleared", data_ready, 0);
    rx_valid = 1'b1; rx_byte = 8'h55; rx_break = 1'b1; cyc(); rx_valid = 1'b0; rx_break = 1'b0;
    chk("R7 both level", rx_level, 1);
    rd(d); chk("R7 both zero", d, 0);

    // idle timeout, char_ticks=3 -> 12 edges
    push(8'h41); push(8'h42);
    repeat (11) cyc();
    chk("R9 early", tmo_pend, 0);
    cyc();
    chk("R9 fire", tmo_pend, 1);
    rd(d);
    chk("R4 tmo data", d, 8'h41);
    chk("R10 read clears", tmo_pend, 0);
    repeat (11) cyc();
    chk("R9 restart early", tmo_pend, 0);
    cyc();
    chk("R9 restart fire", tmo_pend, 1);
    rd(d);
    chk("R10 last read", tmo_pend, 0);
    repeat (30) cyc();
    chk("R10 empty quiet", tmo_pend, 0);
    push(8'h01); repeat (8) cyc(); push(8'h02);
    repeat (11) cyc();
    chk("R9 push restart", tmo_pend, 0);
    cyc();
    chk("R9 push fire", tmo_pend, 1);

    // char time sweep
    for (int t = 1; t <= 5; t++) begin
      char_ticks = 16'(t);
      ctl(8'hC3, txf);
      chk("R2 pend cleared", tmo_pend, 0);
      chk("R2 level cleared", rx_level, 0);
      push(8'(t));
      repeat (4 * t - 1) cyc();
      chk("R9 sweep early", tmo_pend, 0);
      cyc();
      chk("R9 sweep fire", tmo_pend, 1);
    end
    brk_ev();
    ctl(8'hC3, txf);
    chk("R2 brk cleared", brk_flag, 0);
    chk("R1 no txf", txf, 0);

    // control retention and transmit flush
    ctl(8'hFF, txf);
    chk("R1 bit2 txf", txf, 1);
    chk("R1 mask", ctl_q, 8'hC9);
    push(8'h77);
    ctl(8'hC8, txf);
    chk("R1 flip off txf", txf, 1);
    chk("R1 mask off", ctl_q, 8'hC8);
    chk("R2 flip empties", rx_level, 0);
    ctl(8'hC9, txf);
    chk("R1 flip on txf", txf, 1);
    ctl(8'h41, txf);
    chk("R1 quiet txf", txf, 0);
    chk("R1 ctl 41", ctl_q, 8'h41);
    chk("R3 trig code 01 empty", trig_hit, 0);

    finish_run();
  end
endmodule